// File: doc/BRIEF.md
# Colour Channel Sampling Sequencer

This block decides which of the three colour inputs (red, green, blue) of a three-input line-sensor front end is selected for sampling, and labels every conversion with the channel it came from. It watches two asynchronous strobes, the sample-data strobe and the converter strobe. It passes each one through a synchronizer into the system clock and turns it into a single-cycle rising-edge event. The select moves on those events, according to a small set of configuration fields.

Three modes are supported. In three-channel mode the select cycles through all three colours in either red-green-blue or blue-green-red order, and every rising edge of the sample-data strobe re-arms it to the first colour of that order. In single-channel mode the select stays on the one enabled colour. In two-channel mode the select alternates between the two enabled colours, and the order field decides which of them leads. An enable mask that fits neither case outside three-channel mode is flagged as an error. A strobe-delay field is not acted on; the block only carries it through.

Top module: `rgb_chan_sequencer`

## Requirements
- R1: While reset is asserted and right after it, sel_onehot is 3'b001 (red), chan_tag is 0, tag_valid is 0 and cfg_error is 0. sel_onehot bit 0 is red, bit 1 is green and bit 2 is blue.
- R2: In three-channel mode (cfg_three_ch=1) with cfg_order_rgb=1, each converter-strobe rising edge moves the select red to green, green to blue and blue to red. It also pulses tag_valid for one cycle, with chan_tag giving the channel selected before the edge (0 red, 1 green, 2 blue).
- R3: In three-channel mode with cfg_order_rgb=0, each converter-strobe rising edge moves the select blue to green, green to red and red to blue, and tags the conversion as in R2.
- R4: In three-channel mode a sample-data strobe rising edge sets the select to red (order 1) or blue (order 0) and emits no tag. It takes priority over a converter edge detected in the same cycle, which is still tagged. cfg_enable has no effect in this mode.
- R5: Outside three-channel mode with exactly one bit of cfg_enable set (bit 2 red, bit 1 green, bit 0 blue), the select takes that channel one clock later and stays there. Converter edges tag it without moving it, and cfg_order_rgb has no effect.
- R6: Outside three-channel mode with exactly two enable bits set, the leading channel is the enabled one with the lower tag when cfg_order_rgb=1 and the higher tag when 0. A converter edge selects the other enabled channel when the lead is selected, and the lead otherwise.
- R7: Outside three-channel mode with zero or three enable bits set, the select is held at red and cfg_error is high, both one clock after the configuration is applied. Converter edges are still tagged.
- R8: With the default two synchronizer stages, a strobe's effect appears at the outputs on the third rising clock edge after the strobe goes high. A strobe held high produces only one step.
- R9: delay_out equals cfg_delay one clock later.
- R10: Outside three-channel mode the sample-data strobe has no effect on the select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_three_ch | input | 1 | 1 selects three-channel mode |
| cfg_order_rgb | input | 1 | 1 gives red-first order, 0 blue-first |
| cfg_enable | input | 3 | Channel enables: bit 2 red, bit 1 green, bit 0 blue |
| cfg_delay | input | DLY_W | Strobe-delay field, carried through |
| data_strobe | input | 1 | Asynchronous sample-data strobe |
| conv_strobe | input | 1 | Asynchronous converter strobe |
| sel_onehot | output | 3 | Registered one-hot select: bit 0 red, 1 green, 2 blue |
| chan_tag | output | 2 | Channel of the last conversion |
| tag_valid | output | 1 | One-cycle pulse per conversion |
| cfg_error | output | 1 | Enable mask illegal for the selected mode |
| delay_out | output | DLY_W | Registered copy of cfg_delay |

## Verification
A strobe event reaches the outputs SYNC_STAGES+1 rising edges after the strobe goes high: two synchronizer flops, then the edge-history flop that sets the output registers. With the defaults that is the third edge. Configuration-driven results (single-channel select, error hold, delay field) are due one edge after the change. The bench drives every input on a falling edge and samples on the third falling edge after a strobe is raised. The latency test also checks, one falling edge earlier, that the select and tag have not moved yet, and one edge later that tag_valid has dropped again.

// File: rtl/cs_pkg.sv
package cs_pkg;
   typedef enum logic [1:0] {
      CH_RED   = 2'd0,
      CH_GREEN = 2'd1,
      CH_BLUE  = 2'd2
   } chan_e;

   typedef enum logic [1:0] {
      MODE_ERR   = 2'd0,
      MODE_ONE   = 2'd1,
      MODE_TWO   = 2'd2,
      MODE_THREE = 2'd3
   } mode_e;

   localparam int NUM_CH = 3;
   localparam int TAG_W  = 2;

   function automatic logic [NUM_CH-1:0] ch_onehot(chan_e c);
      return (NUM_CH)'(1) << c;
   endfunction
endpackage

// File: rtl/cs_strobe_sync.sv
module cs_strobe_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] rise
);
   initial begin
      if (STAGES < 2) $error("cs_strobe_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_lane
      logic [STAGES-1:0] chain;
      logic              last;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            chain <= '0;
            last  <= 1'b0;
         end else begin
            chain <= {chain[STAGES-2:0], async_in[i]};
            last  <= chain[STAGES-1];
         end
      end

      assign rise[i] = chain[STAGES-1] & ~last;
   end
endmodule

// File: rtl/cs_route_plan.sv
module cs_route_plan
   import cs_pkg::*;
(
   input  logic       three_ch,
   input  logic       order_rgb,
   input  logic [2:0] enable,
   input  chan_e      cur,
   output mode_e      mode,
   output chan_e      first,
   output chan_e      step,
   output chan_e      single
);
   logic [1:0] n_en;
   chan_e      low_en, high_en, partner;

   assign n_en = 2'(enable[2]) + 2'(enable[1]) + 2'(enable[0]);

   always_comb begin
      low_en  = enable[2] ? CH_RED  : (enable[1] ? CH_GREEN : CH_BLUE);
      high_en = enable[0] ? CH_BLUE : (enable[1] ? CH_GREEN : CH_RED);
      single  = low_en;

      if (three_ch)       mode = MODE_THREE;
      else if (n_en == 1) mode = MODE_ONE;
      else if (n_en == 2) mode = MODE_TWO;
      else                mode = MODE_ERR;

      first   = CH_RED;
      step    = CH_RED;
      partner = CH_RED;
      unique case (mode)
         MODE_THREE: begin
            first = order_rgb ? CH_RED : CH_BLUE;
            unique case (cur)
               CH_RED:   step = order_rgb ? CH_GREEN : CH_BLUE;
               CH_GREEN: step = order_rgb ? CH_BLUE  : CH_RED;
               default:  step = order_rgb ? CH_RED   : CH_GREEN;
            endcase
         end
         MODE_TWO: begin
            first   = order_rgb ? low_en  : high_en;
            partner = order_rgb ? high_en : low_en;
            step    = (cur == first) ? partner : first;
         end
         MODE_ONE: begin
            first = low_en;
            step  = low_en;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/cs_sel_state.sv
module cs_sel_state
   import cs_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  mode_e             mode,
   input  chan_e             first,
   input  chan_e             step,
   input  chan_e             single,
   input  logic              conv_rise,
   input  logic              data_rise,
   output chan_e             cur,
   output logic [NUM_CH-1:0] sel_onehot,
   output logic [TAG_W-1:0]  chan_tag,
   output logic              tag_valid,
   output logic              cfg_error
);
   chan_e nxt;

   always_comb begin
      unique case (mode)
         MODE_ERR:   nxt = CH_RED;
         MODE_ONE:   nxt = single;
         MODE_TWO:   nxt = conv_rise ? step : cur;
         default:    nxt = data_rise ? first : (conv_rise ? step : cur);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur        <= CH_RED;
         sel_onehot <= ch_onehot(CH_RED);
         chan_tag   <= '0;
         tag_valid  <= 1'b0;
         cfg_error  <= 1'b0;
      end else begin
         cur        <= nxt;
         sel_onehot <= ch_onehot(nxt);
         tag_valid  <= conv_rise;
         cfg_error  <= (mode == MODE_ERR);
         if (conv_rise) chan_tag <= cur;
      end
   end
endmodule

// File: rtl/rgb_chan_sequencer.sv
module rgb_chan_sequencer
   import cs_pkg::*;
#(
   parameter int SYNC_STAGES    = 2,
   parameter int DLY_W          = 4,
   parameter bit DLY_REGISTERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_three_ch,
   input  logic             cfg_order_rgb,
   input  logic [2:0]       cfg_enable,
   input  logic [DLY_W-1:0] cfg_delay,
   input  logic             data_strobe,
   input  logic             conv_strobe,
   output logic [2:0]       sel_onehot,
   output logic [1:0]       chan_tag,
   output logic             tag_valid,
   output logic             cfg_error,
   output logic [DLY_W-1:0] delay_out
);
   localparam int N_STROBES = 2;
   localparam int IDX_CONV  = 0;
   localparam int IDX_DATA  = 1;

   initial begin
      if (SYNC_STAGES < 2) $error("rgb_chan_sequencer: SYNC_STAGES below 2");
      if (DLY_W < 1)       $error("rgb_chan_sequencer: DLY_W must be positive");
   end

   logic [N_STROBES-1:0] strobe_rise;
   mode_e mode;
   chan_e first, step, single, cur;

   cs_strobe_sync #(.STAGES(SYNC_STAGES), .WIDTH(N_STROBES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in ({data_strobe, conv_strobe}),
      .rise     (strobe_rise)
   );

   cs_route_plan u_plan (
      .three_ch  (cfg_three_ch),
      .order_rgb (cfg_order_rgb),
      .enable    (cfg_enable),
      .cur       (cur),
      .mode      (mode),
      .first     (first),
      .step      (step),
      .single    (single)
   );

   cs_sel_state u_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode),
      .first      (first),
      .step       (step),
      .single     (single),
      .conv_rise  (strobe_rise[IDX_CONV]),
      .data_rise  (strobe_rise[IDX_DATA]),
      .cur        (cur),
      .sel_onehot (sel_onehot),
      .chan_tag   (chan_tag),
      .tag_valid  (tag_valid),
      .cfg_error  (cfg_error)
   );

   if (DLY_REGISTERED) begin : g_dly_reg
      always_ff @(posedge clk) begin
         if (!rst_n) delay_out <= '0;
         else        delay_out <= cfg_delay;
      end
   end else begin : g_dly_wire
      assign delay_out = cfg_delay;
   end
endmodule

// File: rtl/rgb_chan_sequencer_chk.sv
module rgb_chan_sequencer_chk #(
   parameter int DLY_W          = 4,
   parameter bit DLY_REGISTERED = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_three_ch,
   input logic             cfg_order_rgb,
   input logic [2:0]       cfg_enable,
   input logic [DLY_W-1:0] cfg_delay,
   input logic [2:0]       sel_onehot,
   input logic [1:0]       chan_tag,
   input logic             tag_valid,
   input logic             cfg_error,
   input logic [DLY_W-1:0] delay_out
);
   function automatic logic [1:0] idx_of(logic [2:0] s);
      return s[0] ? 2'd0 : (s[1] ? 2'd1 : 2'd2);
   endfunction

   function automatic logic [2:0] succ_of(logic [2:0] s, logic rgb);
      return rgb ? {s[1:0], s[2]} : {s[0], s[2:1]};
   endfunction

   logic single_cfg;
   assign single_cfg = !cfg_three_ch && ($countones(cfg_enable) == 1);

   a_r1_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(sel_onehot) == 1);

   a_r2_tag_prior_sel: assert property (@(posedge clk) disable iff (!rst_n)
      tag_valid |-> chan_tag == idx_of($past(sel_onehot)));

   a_r4_three_ch_step: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(cfg_three_ch) && !$stable(sel_onehot)) |->
         (sel_onehot == succ_of($past(sel_onehot), $past(cfg_order_rgb)) ||
          sel_onehot == ($past(cfg_order_rgb) ? 3'b001 : 3'b100)));

   a_r5_single_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(single_cfg)) |->
         sel_onehot == {$past(cfg_enable[0]), $past(cfg_enable[1]), $past(cfg_enable[2])});

   a_r7_error_red: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_error |-> sel_onehot == 3'b001);

   if (DLY_REGISTERED) begin : g_dly_chk
      a_r9_delay_follow: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> delay_out == $past(cfg_delay));
   end
endmodule

bind rgb_chan_sequencer rgb_chan_sequencer_chk #(
   .DLY_W          (DLY_W),
   .DLY_REGISTERED (DLY_REGISTERED)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_three_ch  (cfg_three_ch),
   .cfg_order_rgb (cfg_order_rgb),
   .cfg_enable    (cfg_enable),
   .cfg_delay     (cfg_delay),
   .sel_onehot    (sel_onehot),
   .chan_tag      (chan_tag),
   .tag_valid     (tag_valid),
   .cfg_error     (cfg_error),
   .delay_out     (delay_out)
);

// File: tb/rgb_chan_sequencer_bench.sv
module rgb_chan_sequencer_bench;
   localparam int DLY_W = 4;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             cfg_three_ch, cfg_order_rgb;
   logic [2:0]       cfg_enable;
   logic [DLY_W-1:0] cfg_delay;
   logic             data_strobe, conv_strobe;
   logic [2:0]       sel_onehot;
   logic [1:0]       chan_tag;
   logic             tag_valid, cfg_error;
   logic [DLY_W-1:0] delay_out;

   int  compared   = 0;
   int  mismatched = 0;
   bit  done       = 1'b0;

   always #5 clk = ~clk;

   rgb_chan_sequencer #(.DLY_W(DLY_W)) u_rgb_chan_sequencer (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_three_ch  (cfg_three_ch),
      .cfg_order_rgb (cfg_order_rgb),
      .cfg_enable    (cfg_enable),
      .cfg_delay     (cfg_delay),
      .data_strobe   (data_strobe),
      .conv_strobe   (conv_strobe),
      .sel_onehot    (sel_onehot),
      .chan_tag      (chan_tag),
      .tag_valid     (tag_valid),
      .cfg_error     (cfg_error),
      .delay_out     (delay_out)
   );

   // entry: three, order, enable[3], action[2] (0 conv, 1 data, 2 none),
   //        sel[3], tag[2], valid, error
   localparam int NV = 23;
   localparam logic [13:0] VEC [NV] = '{
      {1'b1, 1'b1, 3'b100, 2'd0, 3'b010, 2'd0, 1'b1, 1'b0}, // R2
      {1'b1, 1'b1, 3'b100, 2'd0, 3'b100, 2'd1, 1'b1, 1'b0}, // R2
      {1'b1, 1'b1, 3'b100, 2'd0, 3'b001, 2'd2, 1'b1, 1'b0}, // R2 wrap
      {1'b1, 1'b1, 3'b100, 2'd0, 3'b010, 2'd0, 1'b1, 1'b0}, // R2
      {1'b1, 1'b1, 3'b100, 2'd1, 3'b001, 2'd0, 1'b0, 1'b0}, // R4 re-arm red
      {1'b1, 1'b0, 3'b100, 2'd1, 3'b100, 2'd0, 1'b0, 1'b0}, // R4 re-arm blue
      {1'b1, 1'b0, 3'b100, 2'd0, 3'b010, 2'd2, 1'b1, 1'b0}, // R3
      {1'b1, 1'b0, 3'b100, 2'd0, 3'b001, 2'd1, 1'b1, 1'b0}, // R3
      {1'b1, 1'b0, 3'b100, 2'd0, 3'b100, 2'd0, 1'b1, 1'b0}, // R3 wrap
      {1'b1, 1'b0, 3'b000, 2'd0, 3'b010, 2'd2, 1'b1, 1'b0}, // R4 mask ignored
      {1'b0, 1'b1, 3'b010, 2'd0, 3'b010, 2'd1, 1'b1, 1'b0}, // R5 green
      {1'b0, 1'b0, 3'b010, 2'd0, 3'b010, 2'd1, 1'b1, 1'b0}, // R5 order ignored
      {1'b0, 1'b1, 3'b001, 2'd2, 3'b100, 2'd0, 1'b0, 1'b0}, // R5 blue
      {1'b0, 1'b1, 3'b101, 2'd0, 3'b001, 2'd2, 1'b1, 1'b0}, // R6 to lead red
      {1'b0, 1'b1, 3'b101, 2'd0, 3'b100, 2'd0, 1'b1, 1'b0}, // R6
      {1'b0, 1'b1, 3'b101, 2'd1, 3'b100, 2'd0, 1'b0, 1'b0}, // R10
      {1'b0, 1'b0, 3'b101, 2'd0, 3'b001, 2'd2, 1'b1, 1'b0}, // R6 lead blue
      {1'b0, 1'b0, 3'b101, 2'd0, 3'b100, 2'd0, 1'b1, 1'b0}, // R6
      {1'b0, 1'b1, 3'b110, 2'd0, 3'b001, 2'd2, 1'b1, 1'b0}, // R6 red/green
      {1'b0, 1'b1, 3'b110, 2'd0, 3'b010, 2'd0, 1'b1, 1'b0}, // R6
      {1'b0, 1'b1, 3'b111, 2'd2, 3'b001, 2'd0, 1'b0, 1'b1}, // R7 three set
      {1'b0, 1'b1, 3'b000, 2'd0, 3'b001, 2'd0, 1'b1, 1'b1}, // R7 none set
      {1'b1, 1'b1, 3'b000, 2'd2, 3'b001, 2'd0, 1'b0, 1'b0}  // R7 cleared
   };

   task automatic check(string req, int act, int exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_neg(int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   initial begin
      rst_n = 1'b0; cfg_three_ch = 1'b1; cfg_order_rgb = 1'b1;
      cfg_enable = 3'b100; cfg_delay = '0; data_strobe = 1'b0; conv_strobe = 1'b0;
      wait_neg(4);
      check("R1 sel in reset", sel_onehot, 3'b001);
      rst_n = 1'b1;
      wait_neg(1);
      check("R1 sel", sel_onehot, 3'b001);
      check("R1 tag", chan_tag, 0);
      check("R1 valid", tag_valid, 0);
      check("R1 error", cfg_error, 0);

      for (int v = 0; v < NV; v++) begin
         cfg_three_ch  = VEC[v][13];
         cfg_order_rgb = VEC[v][12];
         cfg_enable    = VEC[v][11:9];
         conv_strobe   = (VEC[v][8:7] == 2'd0);
         data_strobe   = (VEC[v][8:7] == 2'd1);
         wait_neg(3);
         check($sformatf("vec %0d sel", v), sel_onehot, VEC[v][6:4]);
         check($sformatf("vec %0d valid", v), tag_valid, VEC[v][1]);
         if (VEC[v][1]) check($sformatf("vec %0d tag", v), chan_tag, VEC[v][3:2]);
         check($sformatf("vec %0d error", v), cfg_error, VEC[v][0]);
         conv_strobe = 1'b0;
         data_strobe = 1'b0;
         wait_neg(3);
      end

      // R8 latency and single step on a held strobe (3ch RGB, select red)
      conv_strobe = 1'b1;
      wait_neg(2);
      check("R8 sel before due edge", sel_onehot, 3'b001);
      check("R8 valid before due edge", tag_valid, 0);
      wait_neg(1);
      check("R8 sel on due edge", sel_onehot, 3'b010);
      check("R8 valid on due edge", tag_valid, 1);
      check("R8 tag on due edge", chan_tag, 0);
      wait_neg(1);
      check("R8 valid one cycle", tag_valid, 0);
      wait_neg(3);
      check("R8 held strobe single step", sel_onehot, 3'b010);
      conv_strobe = 1'b0;
      wait_neg(3);

      // R4 both strobes at once: data wins, conversion tagged (select green)
      conv_strobe = 1'b1;
      data_strobe = 1'b1;
      wait_neg(3);
      check("R4 priority sel", sel_onehot, 3'b001);
      check("R4 priority valid", tag_valid, 1);
      check("R4 priority tag", chan_tag, 1);
      conv_strobe = 1'b0;
      data_strobe = 1'b0;
      wait_neg(3);

      // R9 delay field pass-through
      cfg_delay = 4'hA;
      wait_neg(1);
      check("R9 delay", delay_out, 4'hA);
      cfg_delay = 4'h3;
      wait_neg(1);
      check("R9 delay change", delay_out, 4'h3);

      // R5 one-clock settle, then R1 reset mid-run
      cfg_three_ch = 1'b0;
      cfg_enable   = 3'b001;
      wait_neg(1);
      check("R5 settle one clock", sel_onehot, 3'b100);
      rst_n = 1'b0;
      wait_neg(1);
      check("R1 mid-run reset sel", sel_onehot, 3'b001);
      check("R1 mid-run reset tag", chan_tag, 0);
      check("R1 mid-run reset error", cfg_error, 0);
      cfg_three_ch = 1'b1;
      cfg_enable   = 3'b100;
      rst_n = 1'b1;
      wait_neg(2);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule